// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block keeps track of where a packet receiver may place incoming bytes inside a ring of 256-byte pages in a shared packet memory. Four 8-bit page registers define the ring: the first page of the ring (`start_pg`), the page one past its end (`stop_pg`), the host's protection page (`bnd_pg`), and the page where the next packet will begin (`cur_pg`). A page number is the upper byte of the 16-bit memory address.

The receiver marks a packet with `pkt_start`, offers bytes one per cycle on `byte_vld`, and closes the packet with `pkt_end`. For each byte the block either grants a write at `wr_addr` or refuses it. The write position never enters a page whose successor is the protection page. When a packet runs into that limit, the block raises `ovf` and discards the rest of the packet. A packet that is accepted moves `cur_pg` forward to the first page after its last byte, so every packet starts on a fresh page. A dropped packet leaves `cur_pg` unchanged.

The host owns `bnd_pg`. It advances that page as it consumes data, writing it through the same configuration port that sets the other three registers.

Top module: `rxring_page_mgr`

## Requirements
- R1: After reset the registers read start 46h, stop 60h, boundary 46h and current 47h. `wr_en` and `ovf` are low.
- R2: A cycle with `cfg_we` high loads `cfg_data` into the register chosen by `cfg_sel` (0 start, 1 stop, 2 boundary, 3 current). The new value shows on the matching output from the next cycle.
- R3: After `pkt_start`, the first byte of the packet is written at address {cur_pg, 00h}. Each later accepted byte is written at the previous address plus one.
- R4: After a byte at offset FFh, writing moves to offset 00h of the next page. That next page is `start_pg` when the current page plus one equals `stop_pg`, and the current page plus one otherwise.
- R5: A byte at offset 00h of page P is refused when the page after P (using the R4 wrap rule) equals `bnd_pg`. In that cycle `wr_en` is low and `ovf` is high for one cycle.
- R6: Once a packet has had a refused byte, every later byte of that packet is refused, with `wr_en` low and `ovf` low.
- R7: When `pkt_end` closes a packet that had no refused byte, `cur_pg` changes on the next cycle. It becomes the write page if the write offset is 00h, and the page after the write page otherwise. A packet with no bytes therefore leaves `cur_pg` unchanged.
- R8: When `pkt_end` closes a dropped packet, `cur_pg` keeps its value.
- R9: `byte_vld` is ignored outside a packet, and also in any cycle that carries `pkt_start` or `pkt_end`. In those cycles `wr_en` stays low.
- R10: A `pkt_start` inside an open packet abandons that packet without moving `cur_pg`. It restarts writing at {cur_pg, 00h}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 stop, 2 boundary, 3 current |
| cfg_data | input | 8 | Page value to write |
| pkt_start | input | 1 | Opens a packet |
| pkt_end | input | 1 | Closes the open packet |
| byte_vld | input | 1 | Receiver offers one byte this cycle |
| wr_en | output | 1 | Offered byte is granted at wr_addr |
| wr_addr | output | 16 | Memory address for the offered byte |
| ovf | output | 1 | One-cycle pulse when a packet is refused at the boundary |
| start_pg | output | 8 | First page of the ring |
| stop_pg | output | 8 | Page one past the ring's end |
| bnd_pg | output | 8 | Host protection page |
| cur_pg | output | 8 | Page where the next packet begins |

## Verification
The assertions check four things on every cycle. Outside a packet no byte is granted. A refusal never coincides with a grant and always latches the drop state. A granted byte moves the address by one within its page, or wraps to the start page at the ring's end. `cur_pg` changes only through a commit or a host write. Only the bench's scenarios can show the page-level results. These include where a packet's pages end up after rounding up, the exact byte at which the boundary stops a long packet, and that zero-byte, restarted and dropped packets leave the current page where the requirements put it. Random packet lengths combined with random boundary advances cover many ring positions that the directed cases do not reach.

// File: rtl/rxring_pkg.sv
// Package: shared encodings for the receive ring page manager.
// Assumes: register select is a 2-bit field decoded by the register file.
package rxring_pkg;
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_STOP  = 2'd1,
        SEL_BND   = 2'd2,
        SEL_CUR   = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/rxring_regs.sv
// Module: rxring_regs
// Holds the four ring page registers. The host writes them through a
// select/data port. The packet tracker commits a new current page when a
// packet is accepted.
// Assumes: a host write to the current page wins over a same-cycle commit.
module rxring_regs
    import rxring_pkg::*;
#(
    parameter int PW = 8,
    parameter logic [PW-1:0] RST_START = 8'h46,
    parameter logic [PW-1:0] RST_STOP  = 8'h60,
    parameter logic [PW-1:0] RST_BND   = 8'h46,
    parameter logic [PW-1:0] RST_CUR   = 8'h47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [PW-1:0] cfg_data,
    input  logic          commit_vld,
    input  logic [PW-1:0] commit_pg,
    output logic [PW-1:0] start_q,
    output logic [PW-1:0] stop_q,
    output logic [PW-1:0] bnd_q,
    output logic [PW-1:0] cur_q
);
    logic host_cur_we;

    // Decode a host write aimed at the current-page register.
    always_comb host_cur_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CUR);

    // Ring bound registers and boundary, host-written only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= RST_START;
            stop_q  <= RST_STOP;
            bnd_q   <= RST_BND;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_START: start_q <= cfg_data;
                SEL_STOP:  stop_q  <= cfg_data;
                SEL_BND:   bnd_q   <= cfg_data;
                default:   ;
            endcase
        end
    end

    // Current page: host write first, otherwise packet commit.
    always_ff @(posedge clk) begin
        if (!rst_n)           cur_q <= RST_CUR;
        else if (host_cur_we) cur_q <= cfg_data;
        else if (commit_vld)  cur_q <= commit_pg;
    end

    // R8
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_vld && !host_cur_we) |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/rxring_guard.sv
// Module: rxring_guard
// Computes the page after the write page with ring wrap, decides whether
// an offered byte is granted or refused at the protection page, and
// reports the overflow pulse.
// Assumes: stop page lies above start page; purely combinational.
module rxring_guard #(
    parameter int PW = 8,
    parameter int OW = 8
) (
    input  logic [PW-1:0] wp_pg,
    input  logic [OW-1:0] wp_off,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    input  logic [PW-1:0] bnd_pg,
    input  logic          busy,
    input  logic          drop,
    input  logic          byte_vld,
    input  logic          pkt_start,
    input  logic          pkt_end,
    output logic [PW-1:0] nxt_pg,
    output logic          wr_en,
    output logic          ovf
);
    localparam logic [PW-1:0] ONE_PG = PW'(1);

    logic [PW-1:0] inc_pg;
    logic          offered;
    logic          blocked;

    // Page after the write page, wrapping at the stop page.
    always_comb begin
        inc_pg = wp_pg + ONE_PG;
        nxt_pg = (inc_pg == stop_pg) ? start_pg : inc_pg;
    end

    // Grant or refuse the offered byte.
    always_comb begin
        offered = byte_vld && busy && !drop && !pkt_start && !pkt_end;
        blocked = (wp_off == '0) && (nxt_pg == bnd_pg);
        wr_en   = offered && !blocked;
        ovf     = offered && blocked;
    end
endmodule

// File: rtl/rxring_wptr.sv
// Module: rxring_wptr
// Tracks one packet: open/closed state, drop state and the page/offset
// write position. Issues a current-page commit when an accepted packet ends.
// Assumes: pkt_start takes priority over pkt_end in the same cycle.
module rxring_wptr #(
    parameter int PW = 8,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic          pkt_end,
    input  logic          wr_en,
    input  logic          ovf,
    input  logic [PW-1:0] cur_pg,
    input  logic [PW-1:0] nxt_pg,
    input  logic [PW-1:0] start_pg,
    input  logic [PW-1:0] stop_pg,
    output logic          busy,
    output logic          drop,
    output logic [PW-1:0] wp_pg,
    output logic [OW-1:0] wp_off,
    output logic          commit_vld,
    output logic [PW-1:0] commit_pg
);
    localparam logic [OW-1:0] ONE_OFF = OW'(1);
    localparam logic [PW-1:0] ONE_PG  = PW'(1);

    // Commit on a clean end; round up to the next page when partly filled.
    always_comb begin
        commit_vld = busy && pkt_end && !pkt_start && !drop;
        commit_pg  = (wp_off == '0) ? wp_pg : nxt_pg;
    end

    // Packet state and drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            drop <= 1'b0;
        end else if (pkt_start) begin
            busy <= 1'b1;
            drop <= 1'b0;
        end else if (pkt_end) begin
            busy <= 1'b0;
        end else if (ovf) begin
            drop <= 1'b1;
        end
    end

    // Write position: load at start, step on each granted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_pg  <= '0;
            wp_off <= '0;
        end else if (pkt_start) begin
            wp_pg  <= cur_pg;
            wp_off <= '0;
        end else if (wr_en) begin
            wp_off <= wp_off + ONE_OFF;
            if (wp_off == '1) wp_pg <= nxt_pg;
        end
    end

    // R9
    idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp_off != '1) |=> (wp_off == $past(wp_off) + ONE_OFF));
    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wp_off == '1 && (wp_pg + ONE_PG) == stop_pg)
            |=> (wp_pg == $past(start_pg) && wp_off == '0));
    // R6
    drop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> drop);
endmodule

// File: rtl/rxring_page_mgr.sv
// Module: rxring_page_mgr (top)
// Receive ring page manager: register file, packet write tracker and
// boundary guard. Grants per-byte write addresses inside a ring of pages
// and refuses a packet that would reach the host protection page.
// Assumes: one byte per cycle; host keeps current page = boundary + 1 at init.
module rxring_page_mgr #(
    parameter int PW = 8,
    parameter int OW = 8,
    parameter logic [PW-1:0] RST_START = 8'h46,
    parameter logic [PW-1:0] RST_STOP  = 8'h60,
    parameter logic [PW-1:0] RST_BND   = 8'h46,
    parameter logic [PW-1:0] RST_CUR   = 8'h47
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [PW-1:0]    cfg_data,
    input  logic             pkt_start,
    input  logic             pkt_end,
    input  logic             byte_vld,
    output logic             wr_en,
    output logic [PW+OW-1:0] wr_addr,
    output logic             ovf,
    output logic [PW-1:0]    start_pg,
    output logic [PW-1:0]    stop_pg,
    output logic [PW-1:0]    bnd_pg,
    output logic [PW-1:0]    cur_pg
);
    logic          busy;
    logic          drop;
    logic [PW-1:0] wp_pg;
    logic [OW-1:0] wp_off;
    logic [PW-1:0] nxt_pg;
    logic          commit_vld;
    logic [PW-1:0] commit_pg;

    rxring_regs #(
        .PW(PW), .RST_START(RST_START), .RST_STOP(RST_STOP),
        .RST_BND(RST_BND), .RST_CUR(RST_CUR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .commit_vld(commit_vld), .commit_pg(commit_pg),
        .start_q(start_pg), .stop_q(stop_pg), .bnd_q(bnd_pg), .cur_q(cur_pg)
    );

    rxring_guard #(.PW(PW), .OW(OW)) u_guard (
        .wp_pg(wp_pg), .wp_off(wp_off),
        .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
        .busy(busy), .drop(drop), .byte_vld(byte_vld),
        .pkt_start(pkt_start), .pkt_end(pkt_end),
        .nxt_pg(nxt_pg), .wr_en(wr_en), .ovf(ovf)
    );

    rxring_wptr #(.PW(PW), .OW(OW)) u_wptr (
        .clk(clk), .rst_n(rst_n),
        .pkt_start(pkt_start), .pkt_end(pkt_end),
        .wr_en(wr_en), .ovf(ovf),
        .cur_pg(cur_pg), .nxt_pg(nxt_pg),
        .start_pg(start_pg), .stop_pg(stop_pg),
        .busy(busy), .drop(drop), .wp_pg(wp_pg), .wp_off(wp_off),
        .commit_vld(commit_vld), .commit_pg(commit_pg)
    );

    // Address is page in the upper field, offset in the lower.
    always_comb wr_addr = {wp_pg, wp_off};

    // R5
    ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !wr_en);
endmodule

// File: tb/sim_rxring_page_mgr.sv
module sim_rxring_page_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_data = 8'd0;
    logic        pkt_start = 1'b0;
    logic        pkt_end = 1'b0;
    logic        byte_vld = 1'b0;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic        ovf;
    logic [7:0]  start_pg, stop_pg, bnd_pg, cur_pg;

    int n_chk = 0;
    int n_bad = 0;

    // bench reference state
    logic [7:0] m_start, m_stop, m_bnd, m_cur, m_pg, m_off;
    bit         m_drop;

    always #2 clk = ~clk;

    rxring_page_mgr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .pkt_start(pkt_start), .pkt_end(pkt_end),
        .byte_vld(byte_vld), .wr_en(wr_en), .wr_addr(wr_addr), .ovf(ovf),
        .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg)
    );

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p + 8'd1 == m_stop) ? m_start : p + 8'd1;
    endfunction

    function automatic logic [7:0] prv(input logic [7:0] p);
        return (p == m_start) ? m_stop - 8'd1 : p - 8'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we = 0; pkt_start = 0; pkt_end = 0; byte_vld = 0;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = s; cfg_data = d;
        pkt_start = 0; pkt_end = 0; byte_vld = 0;
        case (s)
            2'd0: m_start = d;
            2'd1: m_stop = d;
            2'd2: m_bnd = d;
            default: m_cur = d;
        endcase
        idle();
    endtask

    task automatic start_pkt();
        @(negedge clk);
        cfg_we = 0; pkt_start = 1; pkt_end = 0; byte_vld = 1;
        #1;
        chk(wr_en == 1'b0, "R9 byte with start", wr_en, 0);
        m_pg = m_cur; m_off = 8'h00; m_drop = 0;
    endtask

    task automatic send_byte();
        bit e_en, e_ovf;
        @(negedge clk);
        cfg_we = 0; pkt_start = 0; pkt_end = 0; byte_vld = 1;
        #1;
        if (m_drop) begin
            e_en = 0; e_ovf = 0;
        end else if (m_off == 8'h00 && nxt(m_pg) == m_bnd) begin
            e_en = 0; e_ovf = 1;
        end else begin
            e_en = 1; e_ovf = 0;
        end
        chk(wr_en == e_en, m_drop ? "R6 grant" : "R5 grant", wr_en, e_en);
        chk(ovf == e_ovf, m_drop ? "R6 ovf" : "R5 ovf", ovf, e_ovf);
        if (e_en) begin
            chk(wr_addr == {m_pg, m_off}, (m_off == 0) ? "R4 addr" : "R3 addr",
                wr_addr, {m_pg, m_off});
            m_off = m_off + 8'd1;
            if (m_off == 8'h00) m_pg = nxt(m_pg);
        end
        if (e_ovf) m_drop = 1;
    endtask

    task automatic end_pkt();
        @(negedge clk);
        cfg_we = 0; pkt_start = 0; pkt_end = 1; byte_vld = 1;
        #1;
        chk(wr_en == 1'b0, "R9 byte with end", wr_en, 0);
        if (!m_drop) m_cur = (m_off == 8'h00) ? m_pg : nxt(m_pg);
        idle();
        #1;
        chk(cur_pg == m_cur, m_drop ? "R8 cur kept" : "R7 cur commit", cur_pg, m_cur);
    endtask

    task automatic packet(input int len);
        start_pkt();
        for (int i = 0; i < len; i++) send_byte();
        end_pkt();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // R1 reset state
        chk(start_pg == 8'h46, "R1 start", start_pg, 8'h46);
        chk(stop_pg == 8'h60, "R1 stop", stop_pg, 8'h60);
        chk(bnd_pg == 8'h46, "R1 bnd", bnd_pg, 8'h46);
        chk(cur_pg == 8'h47, "R1 cur", cur_pg, 8'h47);
        chk(wr_en == 0 && ovf == 0, "R1 outputs", {wr_en, ovf}, 0);
        m_start = 8'h46; m_stop = 8'h60; m_bnd = 8'h46; m_cur = 8'h47;

        // R2 register writes
        cfg(2'd2, 8'h50); #1 chk(bnd_pg == 8'h50, "R2 bnd", bnd_pg, 8'h50);
        cfg(2'd3, 8'h51); #1 chk(cur_pg == 8'h51, "R2 cur", cur_pg, 8'h51);
        cfg(2'd0, 8'h40); #1 chk(start_pg == 8'h40, "R2 start", start_pg, 8'h40);
        cfg(2'd1, 8'h70); #1 chk(stop_pg == 8'h70, "R2 stop", stop_pg, 8'h70);
        cfg(2'd0, 8'h46); cfg(2'd1, 8'h60); cfg(2'd2, 8'h46); cfg(2'd3, 8'h47);

        // R9 bytes outside a packet
        @(negedge clk); byte_vld = 1; #1;
        chk(wr_en == 0 && ovf == 0, "R9 idle byte", {wr_en, ovf}, 0);
        @(negedge clk); byte_vld = 0; pkt_end = 1;
        idle(); #1 chk(cur_pg == 8'h47, "R9 idle end", cur_pg, 8'h47);

        packet(60);                       // R7 short packet -> 48
        packet(0);                        // R7 empty packet
        packet(256);                      // R7 exact page -> 49

        // R4 wrap across the stop page
        cfg(2'd3, 8'h5E); cfg(2'd2, 8'h5D);
        packet(600);                      // 5E,5F,46 -> 47

        // R5/R6/R8 boundary stop
        cfg(2'd3, 8'h47); cfg(2'd2, 8'h49);
        packet(1000);

        // R10 restart inside a packet
        cfg(2'd2, 8'h46);
        start_pkt();
        for (int i = 0; i < 20; i++) send_byte();
        start_pkt();
        for (int i = 0; i < 10; i++) send_byte();
        end_pkt();
        chk(cur_pg == 8'h48, "R10 restart commit", cur_pg, 8'h48);

        // random packets with host boundary updates
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(2) == 0) cfg(2'd2, prv(m_cur));
            packet(int'($urandom_range(1514, 60)));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule